// File: doc/BRIEF.md
# Bus Error Injection Engine

This block lets firmware plant a single, precisely aimed fault in the transaction stream on an endpoint's primary bus. Firmware sets up four things through a small write port: a target address, an address mask, a target bus number and an error type. It then arms the injector. Each transaction descriptor carries an operation kind, an address, a bus number, data parity and address parity. The descriptor passes through the block with one cycle of latency.

The first descriptor that matches the programmed target is corrupted in the way the error type asks. A data error flips two data parity bits and an address error flips the address parity bit. The other types raise an abort, ECRC, completer-abort or unsupported-request flag. At that point the injector disarms itself and raises a sticky fired indication.

Error recovery code is exercised by arming the engine, running traffic and observing how the rest of the path reacts to the fault. Transactions that do not match pass through unchanged.

Top module: `bus_err_injector`

## Requirements
- R1: After reset the injector is disarmed, `fired` is 0, and every descriptor passes through with all `out_flags` bits at 0 and both parities unchanged.
- R2: A write with `cfg_sel`=0 loads the target address and `cfg_sel`=1 loads the mask. A write with `cfg_sel`=2 loads the control word: bus number in bits [7:0], error type in bits [11:8], wide mode in bit 12 and arm in bit 16. Writing the control word with bit 16 set arms the injector and clears `fired`. Writing it with bit 16 clear disarms the injector.
- R3: In narrow mode (bit 12 = 0), only mask bits [23:0] take effect. An address matches when it equals the target in every bit that is not masked, and address bits 63:24 are always compared.
- R4: In wide mode (bit 12 = 1), every mask bit set to 1 excludes that address bit from the comparison, across all 64 bits.
- R5: A descriptor whose bus number differs from the programmed bus number is never corrupted.
- R6: Injection is one-shot. After the first matching descriptor the injector disarms and `fired` rises and stays at 1 until the next arming write. Later matching descriptors pass through unchanged.
- R7: The operation kind must suit the error type. Op codes are 0 mem read, 1 mem write, 2 I/O read, 3 I/O write, 4 config read, 5 config write, 6 DMA read and 7 DMA write. Types 1 and 2 match only op codes 0 to 5. Types 3 to 6 match only op codes 6 and 7. Type 7 matches any op code. Types 8 and 9 match only op code 6. Type 0 and types 10 to 15 never match.
- R8: A data parity type (1 or 3) flips exactly `out_dpar` bits 1 and 0, so two bits differ from the input parity.
- R9: An address parity type (2 or 4) inverts `out_apar`.
- R10: The flag types set one bit of `out_flags`: type 5 sets bit 4 (master abort), type 6 sets bit 3 (target abort), type 7 sets bit 2 (ECRC), type 8 sets bit 1 (completer abort) and type 9 sets bit 0 (unsupported request).
- R11: Every input descriptor appears at the outputs exactly one clock later, with its op, address and bus number unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 address, 1 mask, 2 control) |
| cfg_wdata | input | 64 | Register write data |
| txn_valid | input | 1 | Input descriptor valid |
| txn_op | input | 3 | Operation kind |
| txn_addr | input | 64 | Transaction address |
| txn_bus | input | 8 | Bus number |
| txn_dpar | input | 8 | Data parity bits |
| txn_apar | input | 1 | Address parity bit |
| out_valid | output | 1 | Output descriptor valid |
| out_op | output | 3 | Operation kind, delayed |
| out_addr | output | 64 | Address, delayed |
| out_bus | output | 8 | Bus number, delayed |
| out_dpar | output | 8 | Data parity, possibly corrupted |
| out_apar | output | 1 | Address parity, possibly corrupted |
| out_flags | output | 5 | Injected error flags {mabort, tabort, ecrc, cabort, ur} |
| armed | output | 1 | Injector armed |
| fired | output | 1 | Sticky injection indication |

## Verification
Address patterns are run in pairs that differ by a single bit, placed on either side of the 24-bit narrow-mask limit. These pairs show whether the mask reaches bit 24 in narrow mode and whether it reaches bit 63 in wide mode.

Each error type is tried once with an operation kind it accepts and once with one it rejects, which exposes a wrong class table. A second matching descriptor after a hit, and a descriptor on a neighbouring bus number, separate true one-shot behaviour from repeated injection and from matching that ignores the bus number.

// File: rtl/bei_pkg.sv
package bei_pkg;

    typedef enum logic [2:0] {
        OP_MEM_RD = 3'd0, OP_MEM_WR = 3'd1, OP_IO_RD = 3'd2, OP_IO_WR = 3'd3,
        OP_CFG_RD = 3'd4, OP_CFG_WR = 3'd5, OP_DMA_RD = 3'd6, OP_DMA_WR = 3'd7
    } op_e;

    typedef enum logic [3:0] {
        ET_NONE      = 4'd0,
        ET_DPAR_LDST = 4'd1,
        ET_APAR_LDST = 4'd2,
        ET_DPAR_DMA  = 4'd3,
        ET_APAR_DMA  = 4'd4,
        ET_MABORT    = 4'd5,
        ET_TABORT    = 4'd6,
        ET_ECRC      = 4'd7,
        ET_CABORT    = 4'd8,
        ET_UNSUPP    = 4'd9
    } etype_e;

    typedef struct packed {
        logic mabort;
        logic tabort;
        logic ecrc;
        logic cabort;
        logic unsupp;
    } eflags_t;

    localparam int FLAG_W = $bits(eflags_t);

    // Operation class permitted for each error type
    function automatic logic op_fits(input logic [3:0] et, input logic [2:0] op);
        logic ldst, dma;
        ldst = (op <= 3'd5);
        dma  = (op >= 3'd6);
        case (et)
            ET_DPAR_LDST, ET_APAR_LDST:                       op_fits = ldst;
            ET_DPAR_DMA, ET_APAR_DMA, ET_MABORT, ET_TABORT:   op_fits = dma;
            ET_ECRC:                                          op_fits = 1'b1;
            ET_CABORT, ET_UNSUPP:                             op_fits = (op == 3'd6);
            default:                                          op_fits = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/bei_regs.sv
module bei_regs #(
    parameter int ADDR_W = 64,
    parameter int BUS_W  = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              hit,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [ADDR_W-1:0] tgt_mask,
    output logic [BUS_W-1:0]  tgt_bus,
    output logic [3:0]        tgt_type,
    output logic              wide,
    output logic              armed,
    output logic              fired
);
    localparam int TYPE_LSB = BUS_W + (4 - (BUS_W % 4)) % 4;
    localparam int WIDE_BIT = TYPE_LSB + 4;
    localparam int ARM_BIT  = WIDE_BIT + 4;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] mask;
        logic [BUS_W-1:0]  bus;
        logic [3:0]        etype;
        logic              wide;
        logic              armed;
        logic              fired;
    } regs_t;

    regs_t r_q, r_d;
    logic  ctrl_wr;

    always_comb begin
        r_d     = r_q;
        ctrl_wr = cfg_we && (cfg_sel == SEL_W'(2));
        if (hit) begin
            r_d.armed = 1'b0;
            r_d.fired = 1'b1;
        end
        if (cfg_we && cfg_sel == SEL_W'(0)) r_d.addr = cfg_wdata;
        if (cfg_we && cfg_sel == SEL_W'(1)) r_d.mask = cfg_wdata;
        if (ctrl_wr) begin
            r_d.bus   = cfg_wdata[BUS_W-1:0];
            r_d.etype = cfg_wdata[TYPE_LSB +: 4];
            r_d.wide  = cfg_wdata[WIDE_BIT];
            r_d.armed = cfg_wdata[ARM_BIT];
            if (cfg_wdata[ARM_BIT]) r_d.fired = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tgt_addr = r_q.addr;
    assign tgt_mask = r_q.mask;
    assign tgt_bus  = r_q.bus;
    assign tgt_type = r_q.etype;
    assign wide     = r_q.wide;
    assign armed    = r_q.armed;
    assign fired    = r_q.fired;

    // R6
    oneshot_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !ctrl_wr) |=> (!r_q.armed && r_q.fired));
    // R6
    fired_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.fired) |-> $past(r_q.armed));
    // R2
    arm_clears_fired_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && cfg_wdata[ARM_BIT]) |=> (r_q.armed && !r_q.fired));
endmodule

// File: rtl/bei_match.sv
module bei_match
    import bei_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int BUS_W    = 8,
    parameter int NARROW_W = 24
) (
    input  logic              armed,
    input  logic              wide,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [ADDR_W-1:0] tgt_mask,
    input  logic [BUS_W-1:0]  tgt_bus,
    input  logic [3:0]        tgt_type,
    input  logic              txn_valid,
    input  logic [2:0]        txn_op,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic [BUS_W-1:0]  txn_bus,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] NARROW_LIM =
        {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic [ADDR_W-1:0] eff_mask;
    logic              addr_ok, bus_ok, op_ok;

    always_comb begin
        eff_mask = wide ? tgt_mask : (tgt_mask & NARROW_LIM);
        addr_ok  = (((txn_addr ^ tgt_addr) & ~eff_mask) == '0);
        bus_ok   = (txn_bus == tgt_bus);
        op_ok    = op_fits(tgt_type, txn_op);
        hit      = armed && txn_valid && addr_ok && bus_ok && op_ok;
    end
endmodule

// File: rtl/bei_corrupt.sv
module bei_corrupt
    import bei_pkg::*;
#(
    parameter int DPAR_W = 8
) (
    input  logic              hit,
    input  logic [3:0]        tgt_type,
    input  logic [DPAR_W-1:0] in_dpar,
    input  logic              in_apar,
    output logic [DPAR_W-1:0] dpar,
    output logic              apar,
    output eflags_t           flags
);
    localparam logic [DPAR_W-1:0] TWO_BITS = DPAR_W'(3);

    always_comb begin
        dpar  = in_dpar;
        apar  = in_apar;
        flags = '0;
        if (hit) begin
            case (tgt_type)
                ET_DPAR_LDST, ET_DPAR_DMA: dpar = in_dpar ^ TWO_BITS;
                ET_APAR_LDST, ET_APAR_DMA: apar = ~in_apar;
                ET_MABORT:                 flags.mabort = 1'b1;
                ET_TABORT:                 flags.tabort = 1'b1;
                ET_ECRC:                   flags.ecrc   = 1'b1;
                ET_CABORT:                 flags.cabort = 1'b1;
                ET_UNSUPP:                 flags.unsupp = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bus_err_injector.sv
module bus_err_injector
    import bei_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int BUS_W    = 8,
    parameter int DPAR_W   = 8,
    parameter int NARROW_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              txn_valid,
    input  logic [2:0]        txn_op,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic [BUS_W-1:0]  txn_bus,
    input  logic [DPAR_W-1:0] txn_dpar,
    input  logic              txn_apar,
    output logic              out_valid,
    output logic [2:0]        out_op,
    output logic [ADDR_W-1:0] out_addr,
    output logic [BUS_W-1:0]  out_bus,
    output logic [DPAR_W-1:0] out_dpar,
    output logic              out_apar,
    output logic [4:0]        out_flags,
    output logic              armed,
    output logic              fired
);
    typedef struct packed {
        logic              valid;
        logic [2:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [BUS_W-1:0]  bus;
        logic [DPAR_W-1:0] dpar;
        logic              apar;
        eflags_t           flags;
    } stage_t;

    logic [ADDR_W-1:0] tgt_addr, tgt_mask;
    logic [BUS_W-1:0]  tgt_bus;
    logic [3:0]        tgt_type;
    logic              wide, hit, c_apar;
    logic [DPAR_W-1:0] c_dpar;
    eflags_t           c_flags;
    stage_t            s_q, s_d;

    bei_regs #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .SEL_W(2)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .hit(hit), .tgt_addr(tgt_addr),
        .tgt_mask(tgt_mask), .tgt_bus(tgt_bus), .tgt_type(tgt_type),
        .wide(wide), .armed(armed), .fired(fired)
    );

    bei_match #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .NARROW_W(NARROW_W)) u_match (
        .armed(armed), .wide(wide), .tgt_addr(tgt_addr), .tgt_mask(tgt_mask),
        .tgt_bus(tgt_bus), .tgt_type(tgt_type), .txn_valid(txn_valid),
        .txn_op(txn_op), .txn_addr(txn_addr), .txn_bus(txn_bus), .hit(hit)
    );

    bei_corrupt #(.DPAR_W(DPAR_W)) u_corrupt (
        .hit(hit), .tgt_type(tgt_type), .in_dpar(txn_dpar), .in_apar(txn_apar),
        .dpar(c_dpar), .apar(c_apar), .flags(c_flags)
    );

    always_comb begin
        s_d.valid = txn_valid;
        s_d.op    = txn_op;
        s_d.addr  = txn_addr;
        s_d.bus   = txn_bus;
        s_d.dpar  = c_dpar;
        s_d.apar  = c_apar;
        s_d.flags = c_flags;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.valid;
    assign out_op    = s_q.op;
    assign out_addr  = s_q.addr;
    assign out_bus   = s_q.bus;
    assign out_dpar  = s_q.dpar;
    assign out_apar  = s_q.apar;
    assign out_flags = s_q.flags;

    // R5
    other_bus_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_bus != tgt_bus) |=>
        (out_flags == '0 && out_apar == $past(txn_apar) && out_dpar == $past(txn_dpar)));
    // R8
    two_bit_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_dpar != $past(txn_dpar)) |-> ($countones(out_dpar ^ $past(txn_dpar)) >= 2));
    // R10
    single_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_flags));
    // R11
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |=> (out_valid && out_addr == $past(txn_addr) && out_bus == $past(txn_bus)));
endmodule

// File: tb/bus_err_injector_tb.sv
module bus_err_injector_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [63:0] cfg_wdata;
    logic        txn_valid;
    logic [2:0]  txn_op;
    logic [63:0] txn_addr;
    logic [7:0]  txn_bus;
    logic [7:0]  txn_dpar;
    logic        txn_apar;
    logic        out_valid;
    logic [2:0]  out_op;
    logic [63:0] out_addr;
    logic [7:0]  out_bus;
    logic [7:0]  out_dpar;
    logic        out_apar;
    logic [4:0]  out_flags;
    logic        armed, fired;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bus_err_injector u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .txn_valid(txn_valid), .txn_op(txn_op),
        .txn_addr(txn_addr), .txn_bus(txn_bus), .txn_dpar(txn_dpar),
        .txn_apar(txn_apar), .out_valid(out_valid), .out_op(out_op),
        .out_addr(out_addr), .out_bus(out_bus), .out_dpar(out_dpar),
        .out_apar(out_apar), .out_flags(out_flags), .armed(armed), .fired(fired)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    function automatic logic [63:0] ctrl(input bit arm, input bit wd,
                                         input logic [3:0] et, input logic [7:0] bus);
        return (64'(arm) << 16) | (64'(wd) << 12) | (64'(et) << 8) | 64'(bus);
    endfunction

    // Sends one descriptor; outputs are sampled 1 ns after the capturing edge
    task automatic send(input logic [2:0] op, input logic [63:0] a, input logic [7:0] bus);
        @(negedge clk);
        txn_valid = 1'b1; txn_op = op; txn_addr = a; txn_bus = bus;
        txn_dpar = 8'hA5; txn_apar = 1'b0;
        @(posedge clk); #1;
        txn_valid = 1'b0;
    endtask

    function automatic bit clean();
        return (out_flags == 5'd0) && (out_dpar == 8'hA5) && (out_apar == 1'b0);
    endfunction

    task automatic t_reset();
        chk("R1 armed after reset", 64'(armed), 64'd0);
        chk("R1 fired after reset", 64'(fired), 64'd0);
        send(3'd1, 64'h0, 8'h00);
        chk("R1 clean passthrough", 64'(clean()), 64'd1);
        chk("R11 addr", out_addr, 64'h0);
        chk("R11 valid", 64'(out_valid), 64'd1);
    endtask

    task automatic t_narrow();
        wr(2'd0, 64'h1234_5678_9A00_0000);
        wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(2'd2, ctrl(1, 0, 4'd1, 8'h12));
        chk("R2 armed", 64'(armed), 64'd1);
        send(3'd0, 64'h1234_5678_9B00_0000, 8'h12);
        chk("R3 bit24 compared in narrow", 64'(clean()), 64'd1);
        send(3'd0, 64'h1234_5678_9AAB_CDEF, 8'h12);
        chk("R8 two parity bits flipped", 64'(out_dpar), 64'(8'hA5 ^ 8'h03));
        chk("R11 op", 64'(out_op), 64'd0);
        chk("R6 disarmed", 64'(armed), 64'd0);
        chk("R6 fired", 64'(fired), 64'd1);
        send(3'd0, 64'h1234_5678_9A00_0000, 8'h12);
        chk("R6 second match clean", 64'(clean()), 64'd1);
        chk("R6 fired sticky", 64'(fired), 64'd1);
    endtask

    task automatic t_wide();
        wr(2'd1, 64'hFFFF_0000_0000_0000);
        wr(2'd2, ctrl(1, 0, 4'd2, 8'h12));
        chk("R2 arm clears fired", 64'(fired), 64'd0);
        send(3'd2, 64'h9234_5678_9A00_0000, 8'h12);
        chk("R3 high mask ignored narrow", 64'(clean()), 64'd1);
        wr(2'd2, ctrl(1, 1, 4'd2, 8'h12));
        send(3'd2, 64'h9234_5678_9A00_0000, 8'h12);
        chk("R4 wide high mask, R9 apar", 64'(out_apar), 64'd1);
    endtask

    task automatic t_bus_and_disarm();
        wr(2'd1, 64'h0);
        wr(2'd2, ctrl(1, 0, 4'd7, 8'h12));
        send(3'd5, 64'h1234_5678_9A00_0000, 8'h13);
        chk("R5 other bus untouched", 64'(clean()), 64'd1);
        chk("R5 still armed", 64'(armed), 64'd1);
        wr(2'd2, ctrl(0, 0, 4'd7, 8'h12));
        send(3'd5, 64'h1234_5678_9A00_0000, 8'h12);
        chk("R2 disarm write blocks", 64'(clean()), 64'd1);
        wr(2'd2, ctrl(1, 0, 4'd7, 8'h12));
        send(3'd5, 64'h1234_5678_9A00_0000, 8'h12);
        chk("R10 ecrc on config write", 64'(out_flags), 64'h04);
    endtask

    task automatic try_type(input logic [3:0] et, input logic [2:0] bad_op,
                            input logic [2:0] good_op, input logic [4:0] exp_flags,
                            input bit exp_d, input bit exp_a);
        wr(2'd2, ctrl(1, 0, et, 8'h12));
        send(bad_op, 64'h1234_5678_9A00_0000, 8'h12);
        chk("R7 wrong op class clean", 64'(clean()), 64'd1);
        send(good_op, 64'h1234_5678_9A00_0000, 8'h12);
        chk("R10 flags by type", 64'(out_flags), 64'(exp_flags));
        chk("R8 dpar by type", 64'(out_dpar), 64'(exp_d ? 8'hA6 : 8'hA5));
        chk("R9 apar by type", 64'(out_apar), 64'(exp_a));
    endtask

    task automatic t_types();
        try_type(4'd1, 3'd6, 3'd4, 5'h00, 1, 0);
        try_type(4'd2, 3'd7, 3'd3, 5'h00, 0, 1);
        try_type(4'd3, 3'd0, 3'd7, 5'h00, 1, 0);
        try_type(4'd4, 3'd1, 3'd6, 5'h00, 0, 1);
        try_type(4'd5, 3'd2, 3'd7, 5'h10, 0, 0);
        try_type(4'd6, 3'd5, 3'd6, 5'h08, 0, 0);
        try_type(4'd8, 3'd7, 3'd6, 5'h02, 0, 0);
        try_type(4'd9, 3'd7, 3'd6, 5'h01, 0, 0);
        wr(2'd2, ctrl(1, 0, 4'd12, 8'h12));
        send(3'd6, 64'h1234_5678_9A00_0000, 8'h12);
        chk("R7 reserved type never matches", 64'(clean()), 64'd1);
        chk("R7 reserved type stays armed", 64'(armed), 64'd1);
    endtask

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        txn_valid = 1'b0; txn_op = '0; txn_addr = '0; txn_bus = '0;
        txn_dpar = 8'hA5; txn_apar = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_narrow();
        t_wide();
        t_bus_and_disarm();
        t_types();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule